// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM, the kind that takes a select line, a shift clock and one data line each way. A caller gives a 6-bit word address and pulses a start strobe. The block drives the select and clock pins, shifts out a read command, clocks sixteen data bits back in and then releases the device. At the end it presents the word with a one-cycle done pulse.

The shift clock is produced by dividing the system clock. A parameter sets each half-period of the shift clock in system clock cycles, so the same block can match slow or fast parts. The assembled word is returned with its two bytes exchanged relative to the order they arrived in, which lines the result up with a little-endian view of the ROM contents. A caller that needs the whole ROM issues one read per word.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, and whenever no read is running, `ee_sel`, `ee_clk`, `ee_mosi`, `rd_busy` and `rd_done` are all 0.
- R2: The read command is 11 bits sent MSB first: two 0 bits, then 1, 1, 0, then the six address bits from bit 5 down to bit 0. `ee_mosi` is set a half-period before each rising edge of `ee_clk` and does not change on that edge.
- R3: An accepted read first holds `ee_sel` low for one half-period and then raises it. `ee_sel` stays high until the last data clock has ended, and is then dropped. `ee_clk` is never high while `ee_sel` is low.
- R4: Every high phase of `ee_clk` lasts exactly HALF_CYC system clock cycles.
- R5: A read makes exactly 27 rising edges on `ee_clk` while `ee_sel` is high: 11 for the command and 16 for data. `ee_mosi` is 0 during the 16 data clocks.
- R6: `ee_miso` is sampled at the end of each high phase of a data clock. Bits are assembled MSB first into a word W, and `rd_data` returns {W[7:0], W[15:8]}.
- R7: `rd_done` is high for exactly one cycle per read. `rd_data` is valid in that cycle and holds its value until the next `rd_done`.
- R8: A `rd_start` pulse while `rd_busy` is high is ignored. It starts no new transaction and does not alter the command or the result of the read in progress.
- R9: `rd_busy` rises in the cycle after `rd_start` is accepted. It falls in the same cycle that `rd_done` is high, and `rd_done` is never high while `rd_busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Start strobe, accepted only when idle |
| rd_addr | input | ADDR_W (6) | Word address, captured with the strobe |
| rd_busy | output | 1 | High while a read is in progress |
| rd_done | output | 1 | One-cycle pulse when the word is ready |
| rd_data | output | DATA_W (16) | Byte-swapped word read from the device |
| ee_sel | output | 1 | Chip select to the EEPROM, active high |
| ee_clk | output | 1 | Serial shift clock to the EEPROM |
| ee_mosi | output | 1 | Serial data to the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with HALF_CYC at its minimum of 2, ADDR_W of 6 and DATA_W of 16. At these values each shift-clock half is only two system cycles long, so any off-by-one in the divider or in the sampling point shows up directly. The 6-bit address lets the bench reach both address extremes, 0 and 63, next to mixed bit patterns. A behavioural EEPROM model in the bench decodes the command from the pins and answers with a word whose two bytes always differ, so a missing or doubled byte swap cannot go unnoticed.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_CSLO   = 4'd1,
    ST_CSHI   = 4'd2,
    ST_CSETUP = 4'd3,
    ST_CHIGH  = 4'd4,
    ST_CLOW   = 4'd5,
    ST_DGAP   = 4'd6,
    ST_DHIGH  = 4'd7,
    ST_DLOW   = 4'd8,
    ST_END    = 4'd9
  } ee_state_e;

  typedef struct packed {
    logic sel;
    logic sck;
    logic mosi;
  } ee_pins_t;

  // Pin levels belonging to each sequencer state; cmd_bit is the
  // command bit currently on the line.
  function automatic ee_pins_t pins_for(ee_state_e st, logic cmd_bit);
    ee_pins_t p;
    p = '0;
    case (st)
      ST_CSHI:   p = '{sel: 1'b1, sck: 1'b0, mosi: 1'b0};
      ST_CSETUP: p = '{sel: 1'b1, sck: 1'b0, mosi: cmd_bit};
      ST_CHIGH:  p = '{sel: 1'b1, sck: 1'b1, mosi: cmd_bit};
      ST_CLOW:   p = '{sel: 1'b1, sck: 1'b0, mosi: cmd_bit};
      ST_DGAP:   p = '{sel: 1'b1, sck: 1'b0, mosi: 1'b0};
      ST_DHIGH:  p = '{sel: 1'b1, sck: 1'b1, mosi: 1'b0};
      ST_DLOW:   p = '{sel: 1'b1, sck: 1'b0, mosi: 1'b0};
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ee_half_timer.sv
module ee_half_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int HALF_EFF = (HALF_CYC < 2) ? 2 : HALF_CYC;
  localparam int CNT_W    = $clog2(HALF_EFF);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_EFF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == LAST);

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ee_rx_shifter.sv
module ee_rx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              din,
  output logic [DATA_W-1:0] word_swapped
);

  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (sample_en) begin
      sr_d = {sr_q[DATA_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sample_en) begin
      sr_q <= sr_d;
    end
  end

  // Reverse byte order of the word as it was shifted in.
  for (genvar k = 0; k < NBYTES; k++) begin : g_swap
    assign word_swapped[k*8 +: 8] = sr_q[(NBYTES-1-k)*8 +: 8];
  end

endmodule

// File: rtl/ee_read_seq.sv
module ee_read_seq
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  output logic              run,
  output logic              sample_en,
  output logic              finish,
  output ee_pins_t          pins
);

  localparam int CMD_W = ADDR_W + 5;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  ee_state_e          state_q, state_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [CNT_W-1:0]   bits_q, bits_d;
  ee_pins_t           pins_q, pins_d;
  logic               step_en;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    bits_d  = bits_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CSLO;
          cmd_d   = {2'b00, 3'b110, addr};
          bits_d  = CMD_LAST;
        end
      end
      ST_CSLO:   if (tick) state_d = ST_CSHI;
      ST_CSHI:   if (tick) state_d = ST_CSETUP;
      ST_CSETUP: if (tick) state_d = ST_CHIGH;
      ST_CHIGH:  if (tick) state_d = ST_CLOW;
      ST_CLOW: begin
        if (tick) begin
          if (bits_q == '0) begin
            state_d = ST_DGAP;
            bits_d  = DATA_LAST;
          end else begin
            state_d = ST_CSETUP;
            bits_d  = bits_q - 1'b1;
            cmd_d   = {cmd_q[CMD_W-2:0], 1'b0};
          end
        end
      end
      ST_DGAP:   if (tick) state_d = ST_DHIGH;
      ST_DHIGH:  if (tick) state_d = ST_DLOW;
      ST_DLOW: begin
        if (tick) begin
          if (bits_q == '0) begin
            state_d = ST_END;
          end else begin
            state_d = ST_DHIGH;
            bits_d  = bits_q - 1'b1;
          end
        end
      end
      ST_END:    if (tick) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign pins_d  = pins_for(state_d, cmd_d[CMD_W-1]);
  assign step_en = tick || (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      bits_q  <= '0;
      pins_q  <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      bits_q  <= bits_d;
      pins_q  <= pins_d;
    end
  end

  assign run       = (state_q != ST_IDLE);
  assign sample_en = (state_q == ST_DHIGH) && tick;
  assign finish    = (state_q == ST_END) && tick;
  assign pins      = pins_q;

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && (state_q != ST_CSLO)) |=> (state_q != ST_CSLO));

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_sel,
  output logic              ee_clk,
  output logic              ee_mosi,
  input  logic              ee_miso
);

  logic              run;
  logic              tick;
  logic              sample_en;
  logic              finish;
  ee_pins_t          pins;
  logic [DATA_W-1:0] word_sw;
  logic              done_q;
  logic [DATA_W-1:0] data_q;

  ee_half_timer #(.HALF_CYC(HALF_CYC)) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  ee_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rd_start),
    .addr     (rd_addr),
    .tick     (tick),
    .run      (run),
    .sample_en(sample_en),
    .finish   (finish),
    .pins     (pins)
  );

  ee_rx_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .din         (ee_miso),
    .word_swapped(word_sw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (finish) begin
      data_q <= word_sw;
    end
  end

  assign rd_busy = run;
  assign rd_done = done_q;
  assign rd_data = data_q;
  assign ee_sel  = pins.sel;
  assign ee_clk  = pins.sck;
  assign ee_mosi = pins.mosi;

  // R3
  clk_within_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_clk |-> ee_sel);

  // R2
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_clk && !$past(ee_clk)) |-> (ee_mosi == $past(ee_mosi)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rd_busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_busy) |-> rd_done);

endmodule

// File: tb/ee_word_reader_tb_top.sv
`timescale 1ns/1ps
module ee_word_reader_tb_top;

  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int HALF = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_busy, rd_done;
  logic [DW-1:0] rd_data;
  logic          ee_sel, ee_clk, ee_mosi;
  logic          ee_miso = 1'b0;

  always #2 clk = ~clk;

  ee_word_reader #(.ADDR_W(AW), .DATA_W(DW), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
    .ee_sel(ee_sel), .ee_clk(ee_clk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [5:0] a);
    return {2'b10, a, 2'b01, ~a};
  endfunction

  // Behavioural EEPROM model
  int          edges = 0;
  int          last_edges = 0;
  int          txns = 0;
  logic [10:0] cap = '0;
  logic [10:0] last_cmd = '0;
  logic [15:0] shout = '0;

  always @(posedge ee_sel) edges = 0;

  always @(posedge ee_clk) begin
    if (ee_sel) begin
      edges = edges + 1;
      if (edges <= 11) begin
        cap = {cap[9:0], ee_mosi};
        if (edges == 11) shout = rom_word(cap[5:0]);
      end else begin
        #1 ee_miso = shout[15];
        shout = {shout[14:0], 1'b0};
      end
    end
  end

  always @(negedge ee_sel) begin
    txns = txns + 1;
    last_edges = edges;
    last_cmd = cap;
  end

  // Clock high-phase width monitor (R4)
  int hi_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_clk) hi_run++;
      else if (hi_run != 0) begin
        chk(hi_run == HALF, "R4", "sck high width", hi_run, HALF);
        hi_run = 0;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;
  exp_t exp_q[$];
  bit   prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!rd_done, "R7", "done width", rd_done, 0);
      if (rd_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rd_data == e.d, "R6", "swapped word", rd_data, e.d);
          chk(last_cmd == {2'b00, 3'b110, e.a}, "R2", "command", last_cmd,
              {2'b00, 3'b110, e.a});
          chk(last_edges == 27, "R5", "clock count (R3 sel window)",
              last_edges, 27);
          chk(!rd_busy, "R9", "busy at done", rd_busy, 0);
        end
      end
      prev_done = rd_done;
    end
  end

  task automatic do_read(input logic [AW-1:0] a);
    exp_t e;
    while (rd_busy) @(negedge clk);
    e.a = a;
    e.d = {rom_word(a)[7:0], rom_word(a)[15:8]};
    exp_q.push_back(e);
    rd_addr  = a;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk(rd_busy, "R9", "busy after start", rd_busy, 1);
    chk(!ee_sel, "R3", "sel low pulse", ee_sel, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({ee_sel, ee_clk, ee_mosi} == 3'b000, "R1", "pins idle",
        {ee_sel, ee_clk, ee_mosi}, 0);
    chk(!rd_busy && !rd_done, "R1", "busy/done idle", {rd_busy, rd_done}, 0);

    do_read(6'd0);   drain();
    do_read(6'd63);  drain();
    do_read(6'h2A);  drain();
    do_read(6'h15);
    do_read(6'h33);  drain();   // queued back to back

    // R8: strobe during a read is ignored
    t0 = txns;
    do_read(6'h0F);
    repeat (10) @(negedge clk);
    rd_addr  = 6'h30;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    chk(txns == t0 + 1, "R8", "transactions", txns - t0, 1);
    chk(rd_data == {rom_word(6'h0F)[7:0], rom_word(6'h0F)[15:8]}, "R7",
        "data held", rd_data, {rom_word(6'h0F)[7:0], rom_word(6'h0F)[15:8]});
    chk({ee_sel, ee_clk, ee_mosi, rd_busy} == 4'b0000, "R1", "idle after",
        {ee_sel, ee_clk, ee_mosi, rd_busy}, 0);
    finish_run();
  end

endmodule